// File: doc/BRIEF.md
# 802.15.4 Receive Address Filter

This block watches the MAC header of an incoming IEEE 802.15.4 frame, one byte per clock, and decides whether the frame is meant for this node. A start strobe opens a frame, header bytes follow with a valid qualifier, and an end strobe closes the frame. The parser works out from the frame control field how long each addressing field is. It compares each address byte against the node's configuration as the byte arrives, so no header is stored.

Once the last addressing byte has been taken, the block raises a verdict flag and an accept flag. When the frame is accepted, it also gives a single-cycle address-match pulse. The configuration inputs are:

- the node's PAN identifier;
- its 16-bit short address;
- its 64-bit extended address;
- a coordinator flag;
- an enable for the frame-version check.

Payload, checksum and acknowledgement work belong to other blocks.

Top module: `frame_addr_filter`

## Requirements
- R1: The frame control field is the first two bytes, low byte first. Its subfields are:
  - frame type: bits 2:0, where 0 is beacon, 1 is data, 2 is acknowledgement and 3 is MAC command;
  - PAN-ID compression: bit 6;
  - destination mode: bits 11:10;
  - frame version: bits 13:12;
  - source mode: bits 15:14.

  The third byte is the sequence number. Mode 2 means a 16-bit address, mode 3 means a 64-bit address, and modes 0 and 1 mean no address. Each address field is preceded by its 2-byte PAN ID. All multi-byte fields travel low byte first.
- R2: Frame types 4 to 7 are rejected.
- R3: Frame versions 2 and 3 are rejected while `cfg_ver_chk` is 1. They are not rejected on that ground while it is 0.
- R4: A destination PAN ID that is present must equal `cfg_pan_id` or 0xFFFF.
- R5: A 16-bit destination address must equal `cfg_short_addr` or 0xFFFF. A 64-bit destination address must equal `cfg_ext_addr`.
- R6: A beacon's source PAN ID must equal `cfg_pan_id`. The exception is a `cfg_pan_id` of 0xFFFF, in which case any source PAN ID is accepted.
- R7: A data or command frame that has a source address and no destination address is accepted only if `cfg_pan_coord` is 1 and its source PAN ID equals `cfg_pan_id`.
- R8: Acknowledgement frames are never accepted and never produce a match pulse.
- R9: A frame with neither a destination address nor a source address is rejected.
- R10: When the compression bit is set and both addresses are present, the source PAN ID is absent from the byte stream. The destination PAN ID then serves as the source PAN ID.
- R11: `verdict_vld`, `frm_accept` and `addr_match` change on the clock edge that takes the last header byte. `addr_match` is high for exactly one cycle, and only when `frm_accept` is 1. The verdict and accept flags hold until the next start strobe.
- R12: An end strobe, given with `byte_vld` low before the header is complete, sets `verdict_vld` with `frm_accept` at 0 and gives no pulse.
- R13: Reset and the start strobe each clear `verdict_vld`, `frm_accept` and `addr_match` and restart parsing. As a result, consecutive frames are judged independently.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frm_start | input | 1 | Opens a new frame (no byte on this cycle) |
| frm_end | input | 1 | Closes the frame (no byte on this cycle) |
| byte_vld | input | 1 | `byte_data` holds a header byte |
| byte_data | input | 8 | Header byte |
| cfg_pan_id | input | 16 | Own PAN identifier |
| cfg_short_addr | input | 16 | Own short address |
| cfg_ext_addr | input | 64 | Own extended address |
| cfg_pan_coord | input | 1 | Node acts as PAN coordinator |
| cfg_ver_chk | input | 1 | Enables the frame-version check |
| verdict_vld | output | 1 | A decision has been made for the current frame |
| frm_accept | output | 1 | The frame passed the filter |
| addr_match | output | 1 | One-cycle pulse for an accepted frame |

## Verification
Two results are due one edge after the last header byte has been sampled: the verdict itself, and the match pulse if there is one. The pulse must then be gone one edge later, while the accept flag stays unchanged. The end-strobe rejection also shows up one edge after the strobe, and the start strobe clears the flags on its own edge. Inputs are driven on falling edges and outputs are read on the next falling edge. Every frame is also watched byte by byte, so a verdict that appears before the computed header length is reported as a failure. This catches parsers that get a field's length wrong.

// File: rtl/frame_addr_filter.sv
module frame_addr_filter (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        frm_start,
  input  logic        frm_end,
  input  logic        byte_vld,
  input  logic [7:0]  byte_data,
  input  logic [15:0] cfg_pan_id,
  input  logic [15:0] cfg_short_addr,
  input  logic [63:0] cfg_ext_addr,
  input  logic        cfg_pan_coord,
  input  logic        cfg_ver_chk,
  output logic        verdict_vld,
  output logic        frm_accept,
  output logic        addr_match
);

  logic       busy;
  logic [4:0] idx;
  logic [7:0] fcf_lo, fcf_hi;
  logic       dpan_eq, dpan_bc, da_eq, da_bc, span_eq;

  wire [2:0] ftype   = fcf_lo[2:0];
  wire       pan_cmp = fcf_lo[6];
  wire [1:0] dmode   = fcf_hi[3:2];
  wire [1:0] fver    = fcf_hi[5:4];
  wire [1:0] smode   = fcf_hi[7:6];

  wire dst_has = dmode[1];
  wire src_has = smode[1];
  wire sp_omit = pan_cmp && dst_has;

  wire [4:0] dpan_len = dst_has ? 5'd2 : 5'd0;
  wire [4:0] da_len   = !dst_has ? 5'd0 : (dmode[0] ? 5'd8 : 5'd2);
  wire [4:0] sp_len   = (src_has && !sp_omit) ? 5'd2 : 5'd0;
  wire [4:0] sa_len   = !src_has ? 5'd0 : (smode[0] ? 5'd8 : 5'd2);

  wire [4:0] o_dp    = 5'd3;
  wire [4:0] o_da    = o_dp + dpan_len;
  wire [4:0] o_sp    = o_da + da_len;
  wire [4:0] o_sa    = o_sp + sp_len;
  wire [4:0] hdr_len = o_sa + sa_len;

  wire in_dp = (idx >= o_dp) && (idx < o_da);
  wire in_da = (idx >= o_da) && (idx < o_sp);
  wire in_sp = (idx >= o_sp) && (idx < o_sa);

  wire [4:0] p_dp = idx - o_dp;
  wire [4:0] p_da = idx - o_da;
  wire [4:0] p_sp = idx - o_sp;

  wire [7:0] pan_at_dp   = p_dp[0] ? cfg_pan_id[15:8] : cfg_pan_id[7:0];
  wire [7:0] pan_at_sp   = p_sp[0] ? cfg_pan_id[15:8] : cfg_pan_id[7:0];
  wire [7:0] short_at_da = p_da[0] ? cfg_short_addr[15:8] : cfg_short_addr[7:0];
  wire [5:0] ext_sh      = {p_da[2:0], 3'b000};
  wire [7:0] ext_at_da   = cfg_ext_addr[ext_sh +: 8];
  wire [7:0] da_ref      = dmode[0] ? ext_at_da : short_at_da;

  wire n_dpan_eq = dpan_eq && (!in_dp || byte_data == pan_at_dp);
  wire n_dpan_bc = dpan_bc && (!in_dp || byte_data == 8'hFF);
  wire n_da_eq   = da_eq   && (!in_da || byte_data == da_ref);
  wire n_da_bc   = da_bc   && (!in_da || byte_data == 8'hFF);
  wire n_span_eq = span_eq && (!in_sp || byte_data == pan_at_sp);

  wire last_byte = (idx >= 5'd2) && (idx == hdr_len - 5'd1);

  wire ft_ok    = !ftype[2];
  wire fv_ok    = !cfg_ver_chk || !fver[1];
  wire not_ack  = ftype != 3'd2;
  wire any_addr = dst_has || src_has;
  wire dst_ok   = !dst_has ||
                  ((n_dpan_eq || n_dpan_bc) && (n_da_eq || (!dmode[0] && n_da_bc)));
  wire sp_match = sp_omit ? n_dpan_eq : n_span_eq;
  wire bcn_ok   = (ftype != 3'd0) || !src_has || (cfg_pan_id == 16'hFFFF) || sp_match;
  wire src_only = ((ftype == 3'd1) || (ftype == 3'd3)) && !dst_has && src_has;
  wire so_ok    = !src_only || (cfg_pan_coord && sp_match);
  wire pass     = ft_ok && fv_ok && not_ack && any_addr && dst_ok && bcn_ok && so_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy        <= 1'b0;
      idx         <= '0;
      fcf_lo      <= '0;
      fcf_hi      <= '0;
      dpan_eq     <= 1'b1;
      dpan_bc     <= 1'b1;
      da_eq       <= 1'b1;
      da_bc       <= 1'b1;
      span_eq     <= 1'b1;
      verdict_vld <= 1'b0;
      frm_accept  <= 1'b0;
      addr_match  <= 1'b0;
    end else if (frm_start) begin
      busy        <= 1'b1;
      idx         <= '0;
      dpan_eq     <= 1'b1;
      dpan_bc     <= 1'b1;
      da_eq       <= 1'b1;
      da_bc       <= 1'b1;
      span_eq     <= 1'b1;
      verdict_vld <= 1'b0;
      frm_accept  <= 1'b0;
      addr_match  <= 1'b0;
    end else begin
      addr_match <= 1'b0;
      if (busy && byte_vld) begin
        idx     <= idx + 5'd1;
        dpan_eq <= n_dpan_eq;
        dpan_bc <= n_dpan_bc;
        da_eq   <= n_da_eq;
        da_bc   <= n_da_bc;
        span_eq <= n_span_eq;
        if (idx == 5'd0) fcf_lo <= byte_data;
        if (idx == 5'd1) fcf_hi <= byte_data;
        if (last_byte) begin
          busy        <= 1'b0;
          verdict_vld <= 1'b1;
          frm_accept  <= pass;
          addr_match  <= pass;
        end
      end else if (busy && frm_end) begin
        busy        <= 1'b0;
        verdict_vld <= 1'b1;
        frm_accept  <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/frame_addr_filter_chk.sv
module frame_addr_filter_chk (
  input logic clk,
  input logic rst_n,
  input logic frm_start,
  input logic frm_end,
  input logic byte_vld,
  input logic busy,
  input logic verdict_vld,
  input logic frm_accept,
  input logic addr_match
);

  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    addr_match |=> !addr_match); // R11

  AST_PULSE_WITH_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    addr_match |-> (frm_accept && verdict_vld)); // R11

  AST_ACCEPT_NEEDS_VERDICT: assert property (@(posedge clk) disable iff (!rst_n)
    frm_accept |-> verdict_vld); // R11

  AST_VERDICT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (verdict_vld && !frm_start) |=> (verdict_vld && $stable(frm_accept))); // R11

  AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    frm_start |=> (!verdict_vld && !frm_accept && !addr_match)); // R13

  AST_EARLY_END_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && frm_end && !byte_vld && !frm_start) |=> (verdict_vld && !frm_accept && !addr_match)); // R12

endmodule

bind frame_addr_filter frame_addr_filter_chk u_chk (
  .clk(clk), .rst_n(rst_n), .frm_start(frm_start), .frm_end(frm_end),
  .byte_vld(byte_vld), .busy(busy), .verdict_vld(verdict_vld),
  .frm_accept(frm_accept), .addr_match(addr_match)
);

// File: tb/frame_addr_filter_test.sv
module frame_addr_filter_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        frm_start = 1'b0, frm_end = 1'b0, byte_vld = 1'b0;
  logic [7:0]  byte_data = '0;
  logic [15:0] cfg_pan_id = 16'h1234;
  logic [15:0] cfg_short_addr = 16'hABCD;
  logic [63:0] cfg_ext_addr = 64'h0011_2233_4455_6677;
  logic        cfg_pan_coord = 1'b0, cfg_ver_chk = 1'b1;
  logic        verdict_vld, frm_accept, addr_match;

  localparam logic [15:0] MY_PAN   = 16'h1234;
  localparam logic [63:0] MY_SHORT = 64'hABCD;
  localparam logic [63:0] MY_EXT   = 64'h0011_2233_4455_6677;

  int nchk = 0, nfail = 0;
  logic [7:0] fb [0:31];
  int flen = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  frame_addr_filter uut (
    .clk(clk), .rst_n(rst_n), .frm_start(frm_start), .frm_end(frm_end),
    .byte_vld(byte_vld), .byte_data(byte_data), .cfg_pan_id(cfg_pan_id),
    .cfg_short_addr(cfg_short_addr), .cfg_ext_addr(cfg_ext_addr),
    .cfg_pan_coord(cfg_pan_coord), .cfg_ver_chk(cfg_ver_chk),
    .verdict_vld(verdict_vld), .frm_accept(frm_accept), .addr_match(addr_match)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic p8(input logic [7:0] b);
    fb[flen] = b;
    flen++;
  endtask

  task automatic build(input logic [2:0] ft, input logic pc, input logic [1:0] dm,
                       input logic [1:0] fv, input logic [1:0] sm,
                       input logic [15:0] dpan, input logic [63:0] dad,
                       input logic [15:0] span, input logic [63:0] sad);
    logic [15:0] fcf;
    fcf = {sm, fv, dm, 3'b000, pc, 3'b000, ft};
    flen = 0;
    p8(fcf[7:0]); p8(fcf[15:8]); p8(8'h5A);
    if (dm[1]) begin
      p8(dpan[7:0]); p8(dpan[15:8]);
      for (int i = 0; i < (dm[0] ? 8 : 2); i++) p8(dad[8*i +: 8]);
    end
    if (sm[1]) begin
      if (!(pc && dm[1])) begin p8(span[7:0]); p8(span[15:8]); end
      for (int i = 0; i < (sm[0] ? 8 : 2); i++) p8(sad[8*i +: 8]);
    end
  endtask

  task automatic send(input int exp, input string req);
    int early;
    @(negedge clk); frm_start = 1'b1;
    @(negedge clk); frm_start = 1'b0;
    chk("R13", "verdict cleared by start", verdict_vld, 0);
    early = 0;
    for (int i = 0; i < flen; i++) begin
      byte_vld = 1'b1; byte_data = fb[i];
      @(negedge clk);
      if (i < flen - 1 && (verdict_vld || addr_match)) early = 1;
    end
    byte_vld = 1'b0;
    chk("R11", "verdict before header end", early, 0);
    chk(req, "verdict", verdict_vld, 1);
    chk(req, "accept", frm_accept, exp);
    chk(req, "match pulse", addr_match, exp);
    @(negedge clk);
    chk("R11", "pulse one cycle", addr_match, 0);
    chk("R11", "accept held", frm_accept, exp);
  endtask

  task automatic t_reset;
    chk("R13", "reset verdict", verdict_vld, 0);
    chk("R13", "reset accept", frm_accept, 0);
    chk("R13", "reset match", addr_match, 0);
  endtask

  task automatic t_r1_short_compressed;
    build(3'd1, 1'b1, 2'd2, 2'd1, 2'd2, MY_PAN, MY_SHORT, 16'h0, 64'h9876);
    send(1, "R1");
  endtask

  task automatic t_r10_no_compression;
    build(3'd1, 1'b0, 2'd2, 2'd0, 2'd2, MY_PAN, MY_SHORT, 16'h7777, 64'h9876);
    send(1, "R10");
  endtask

  task automatic t_r4_dst_pan;
    build(3'd1, 1'b1, 2'd2, 2'd0, 2'd2, 16'hFFFF, 64'hFFFF, 16'h0, 64'h1);
    send(1, "R4");
    build(3'd1, 1'b1, 2'd2, 2'd0, 2'd2, 16'h1235, MY_SHORT, 16'h0, 64'h1);
    send(0, "R4");
  endtask

  task automatic t_r5_dst_addr;
    build(3'd1, 1'b1, 2'd2, 2'd0, 2'd2, MY_PAN, 64'hABCE, 16'h0, 64'h1);
    send(0, "R5");
    build(3'd3, 1'b1, 2'd3, 2'd0, 2'd3, MY_PAN, MY_EXT, 16'h0, 64'h5);
    send(1, "R5");
    build(3'd1, 1'b1, 2'd3, 2'd0, 2'd2, MY_PAN, MY_EXT ^ 64'h0100_0000_0000_0000, 16'h0, 64'h5);
    send(0, "R5");
    build(3'd1, 1'b1, 2'd3, 2'd0, 2'd2, MY_PAN, 64'hFFFF_FFFF_FFFF_FFFF, 16'h0, 64'h5);
    send(0, "R5");
  endtask

  task automatic t_r2_reserved_type;
    build(3'd5, 1'b1, 2'd2, 2'd0, 2'd2, MY_PAN, MY_SHORT, 16'h0, 64'h1);
    send(0, "R2");
  endtask

  task automatic t_r3_version;
    build(3'd1, 1'b1, 2'd2, 2'd2, 2'd2, MY_PAN, MY_SHORT, 16'h0, 64'h1);
    send(0, "R3");
    cfg_ver_chk = 1'b0;
    send(1, "R3");
    cfg_ver_chk = 1'b1;
  endtask

  task automatic t_r8_ack;
    build(3'd2, 1'b1, 2'd2, 2'd0, 2'd2, MY_PAN, MY_SHORT, 16'h0, 64'h1);
    send(0, "R8");
  endtask

  task automatic t_r9_no_address;
    build(3'd1, 1'b0, 2'd1, 2'd0, 2'd0, 16'h0, 64'h0, 16'h0, 64'h0);
    send(0, "R9");
  endtask

  task automatic t_r6_beacon;
    build(3'd0, 1'b0, 2'd0, 2'd0, 2'd2, 16'h0, 64'h0, 16'h4321, 64'h22);
    send(0, "R6");
    build(3'd0, 1'b0, 2'd0, 2'd0, 2'd2, 16'h0, 64'h0, MY_PAN, 64'h22);
    send(1, "R6");
    cfg_pan_id = 16'hFFFF;
    build(3'd0, 1'b0, 2'd0, 2'd0, 2'd3, 16'h0, 64'h0, 16'h4321, 64'h22);
    send(1, "R6");
    cfg_pan_id = MY_PAN;
  endtask

  task automatic t_r7_source_only;
    build(3'd1, 1'b0, 2'd0, 2'd0, 2'd2, 16'h0, 64'h0, MY_PAN, 64'h33);
    cfg_pan_coord = 1'b0;
    send(0, "R7");
    cfg_pan_coord = 1'b1;
    send(1, "R7");
    build(3'd3, 1'b0, 2'd0, 2'd0, 2'd3, 16'h0, 64'h0, 16'h1334, 64'h33);
    send(0, "R7");
    cfg_pan_coord = 1'b0;
  endtask

  task automatic t_r12_early_end;
    build(3'd1, 1'b1, 2'd3, 2'd0, 2'd2, MY_PAN, MY_EXT, 16'h0, 64'h1);
    @(negedge clk); frm_start = 1'b1;
    @(negedge clk); frm_start = 1'b0;
    for (int i = 0; i < 6; i++) begin
      byte_vld = 1'b1; byte_data = fb[i];
      @(negedge clk);
    end
    byte_vld = 1'b0; frm_end = 1'b1;
    @(negedge clk); frm_end = 1'b0;
    chk("R12", "verdict after early end", verdict_vld, 1);
    chk("R12", "accept after early end", frm_accept, 0);
    chk("R12", "match after early end", addr_match, 0);
  endtask

  task automatic t_r13_back_to_back;
    build(3'd1, 1'b1, 2'd2, 2'd0, 2'd2, MY_PAN, MY_SHORT, 16'h0, 64'h1);
    send(1, "R13");
    build(3'd1, 1'b1, 2'd2, 2'd0, 2'd2, MY_PAN, 64'h1111, 16'h0, 64'h1);
    send(0, "R13");
    chk("R13", "second frame accept", frm_accept, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    t_r1_short_compressed;
    t_r10_no_compression;
    t_r4_dst_pan;
    t_r5_dst_addr;
    t_r2_reserved_type;
    t_r3_version;
    t_r8_ack;
    t_r9_no_address;
    t_r6_beacon;
    t_r7_source_only;
    t_r12_early_end;
    t_r13_back_to_back;
    repeat (2) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    nchk++;
    nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
    $finish;
  end
endmodule